// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Cycle Timer

This block runs one programmed-I/O transfer on a parallel ATA device bus for each host request. It puts the register address on the bus and marks it valid. It then pulls the read or write strobe low and, for a write, drives the 16-bit data word. It releases the strobe, keeps the address (and write data) for a hold interval, and waits out a recovery interval before it accepts more work. A read returns the word sampled from the bus together with the acknowledge.

The phase lengths depend on the selected transfer mode, 0 to 4. Each mode has nanosecond limits that are turned into clock counts when the design is elaborated, from the clock-period parameter `CLK_NS`. The host selects a mode through a small load port. It then issues requests on a request/acknowledge handshake and holds each request until it is acknowledged.

Top module: `pio_cycle_gen`

## Requirements
- R1: After reset, the bus is idle: both strobes are high (inactive), address-valid, data-enable and acknowledge are low, and the active mode is 0.
- R2: A nanosecond limit `t` becomes `(t + CLK_NS) / CLK_NS` clock cycles, using integer division. The mode limits in ns for modes 0..4 are: address setup 70/50/30/30/25; strobe width 290/290/290/80/70; data hold 30/20/15/10/10; address hold 20/15/10/10/10; minimum cycle 600/383/240/180/120.
- R3: The address is valid for exactly the setup count of cycles before the strobe goes low.
- R4: The strobe is low for exactly the strobe-width count of cycles. The same count applies to reads and writes.
- R5: After the strobe rises, address-valid stays high, with the address unchanged, for max(data-hold, address-hold) counts.
- R6: From the accepting clock edge to the edge that raises the acknowledge, a cycle takes max(minimum-cycle count, setup + strobe + hold + 1) cycles. The recovery phase is at least one cycle.
- R7: Read data is captured from `bus_din` on the edge where the read strobe rises. It is presented on `rdata` with the acknowledge and kept until the next read completes.
- R8: A write lowers only `bus_wr_n` and drives `bus_dout` equal to `wdata` with `bus_dout_en` high while the address is valid. A read lowers only `bus_rd_n` and never raises `bus_dout_en`. The two strobes are never low together.
- R9: A mode load with a value 0..4 sets the active mode, which applies from the next accepted request. A value of 5 or more is ignored and leaves the active mode and the timing unchanged.
- R10: The acknowledge is a one-cycle pulse. A request is accepted only while the block is idle and the acknowledge is low, so one held request yields exactly one bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period `CLK_NS` ns |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Load strobe for the transfer mode |
| mode_val | input | 3 | Mode number to load |
| active_mode | output | 3 | Currently selected mode |
| req | input | 1 | Host request, held until `ack` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Device register address |
| wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last read word |
| bus_addr | output | ADDR_W | Address to the device bus |
| bus_addr_valid | output | 1 | Address / select active |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | DATA_W | Data toward the device |
| bus_dout_en | output | 1 | Output enable for `bus_dout` |
| bus_din | input | DATA_W | Data from the device |

## Verification
Every mode from 0 to 4 is run with both a write and a read. The bench measures the setup, strobe, hold and total lengths cycle by cycle, which tells apart modes whose recovery padding dominates (0, 3) from those clamped to one recovery cycle (1, 2, 4). The read responder drives a known word only while the read strobe is low and a different word at other times, so a capture on the wrong edge is exposed. A write placed between two reads shows that read data is held. Loads of out-of-range modes, followed by a timed cycle, show that the timing has not moved.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    localparam int PH_CNT_W  = 8;
    localparam int MODE_W    = 3;
    localparam int NUM_MODES = 5;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SETUP   = 3'd1,
        PH_STROBE  = 3'd2,
        PH_HOLD    = 3'd3,
        PH_RECOVER = 3'd4
    } phase_e;

    typedef logic [PH_CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t setup;
        cnt_t strobe;
        cnt_t hold;
        cnt_t recover;
    } phase_cnt_t;

    function automatic int to_cycles(int ns, int clk_ns);
        return (ns + clk_ns) / clk_ns;
    endfunction

    function automatic int cycle_ns(int m);
        case (m)
            0: return 600;
            1: return 383;
            2: return 240;
            3: return 180;
            default: return 120;
        endcase
    endfunction

    function automatic int setup_ns(int m);
        case (m)
            0: return 70;
            1: return 50;
            4: return 25;
            default: return 30;
        endcase
    endfunction

    function automatic int strobe_ns(int m);
        case (m)
            3: return 80;
            4: return 70;
            default: return 290;
        endcase
    endfunction

    function automatic int dhold_ns(int m);
        case (m)
            0: return 30;
            1: return 20;
            2: return 15;
            default: return 10;
        endcase
    endfunction

    function automatic int ahold_ns(int m);
        case (m)
            0: return 20;
            1: return 15;
            default: return 10;
        endcase
    endfunction

    // Phase counts for one mode; recovery pads the cycle up to the
    // minimum cycle length and never drops below one clock.
    function automatic phase_cnt_t mode_counts(int m, int clk_ns);
        int s, a, dh, ah, h, t0, rec;
        phase_cnt_t r;
        s   = to_cycles(setup_ns(m), clk_ns);
        a   = to_cycles(strobe_ns(m), clk_ns);
        dh  = to_cycles(dhold_ns(m), clk_ns);
        ah  = to_cycles(ahold_ns(m), clk_ns);
        h   = (dh > ah) ? dh : ah;
        t0  = to_cycles(cycle_ns(m), clk_ns);
        rec = t0 - (s + a + h);
        if (rec < 1) rec = 1;
        r.setup   = cnt_t'(s);
        r.strobe  = cnt_t'(a);
        r.hold    = cnt_t'(h);
        r.recover = cnt_t'(rec);
        return r;
    endfunction

endpackage

// File: rtl/pio_mode_table.sv
module pio_mode_table
    import pio_timing_pkg::*;
#(
    parameter int CLK_NS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_val,
    output logic [MODE_W-1:0] mode_q,
    output phase_cnt_t        counts
);

    phase_cnt_t tbl [NUM_MODES];

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        localparam phase_cnt_t ENTRY = mode_counts(m, CLK_NS);
        assign tbl[m] = ENTRY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (mode_wr && (mode_val < MODE_W'(NUM_MODES))) begin
            mode_q <= mode_val;
        end
    end

    always_comb begin
        counts = tbl[0];
        for (int i = 0; i < NUM_MODES; i++) begin
            if (mode_q == MODE_W'(i)) counts = tbl[i];
        end
    end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_timing_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  phase_cnt_t cfg,
    output phase_e     phase,
    output logic       fin,
    output logic       strobe_end
);

    cnt_t       cnt;
    phase_cnt_t cfg_q;
    logic       last;

    assign last       = (cnt == '0);
    assign strobe_end = (phase == PH_STROBE) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            cfg_q <= '0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        cfg_q <= cfg;
                        cnt   <= cfg.setup - cnt_t'(1);
                        phase <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        cnt   <= cfg_q.strobe - cnt_t'(1);
                        phase <= PH_STROBE;
                    end else begin
                        cnt <= cnt - cnt_t'(1);
                    end
                end
                PH_STROBE: begin
                    if (last) begin
                        cnt   <= cfg_q.hold - cnt_t'(1);
                        phase <= PH_HOLD;
                    end else begin
                        cnt <= cnt - cnt_t'(1);
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        cnt   <= cfg_q.recover - cnt_t'(1);
                        phase <= PH_RECOVER;
                    end else begin
                        cnt <= cnt - cnt_t'(1);
                    end
                end
                PH_RECOVER: begin
                    if (last) begin
                        phase <= PH_IDLE;
                        fin   <= 1'b1;
                    end else begin
                        cnt <= cnt - cnt_t'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pio_bus_drive.sv
module pio_bus_drive
    import pio_timing_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  phase_e            phase,
    input  logic              strobe_end,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_valid,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    output logic [DATA_W-1:0] rdata
);

    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              strobing;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                we_q    <= we;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (strobe_end && !we_q) rdata <= bus_din;
        end
    end

    assign strobing       = (phase == PH_STROBE);
    assign bus_addr_valid = (phase == PH_SETUP) || strobing || (phase == PH_HOLD);
    assign bus_rd_n       = !(strobing && !we_q);
    assign bus_wr_n       = !(strobing && we_q);
    assign bus_addr       = addr_q;
    assign bus_dout       = wdata_q;
    assign bus_dout_en    = we_q && bus_addr_valid;

endmodule

// File: rtl/pio_cycle_gen.sv
module pio_cycle_gen
    import pio_timing_pkg::*;
#(
    parameter int CLK_NS = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [2:0]        mode_val,
    output logic [2:0]        active_mode,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_valid,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic [DATA_W-1:0] bus_din
);

    phase_cnt_t counts;
    phase_e     phase;
    logic       strobe_end;
    logic       accept;

    assign accept = req && (phase == PH_IDLE) && !ack;

    pio_mode_table #(.CLK_NS(CLK_NS)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_wr  (mode_wr),
        .mode_val (mode_val),
        .mode_q   (active_mode),
        .counts   (counts)
    );

    pio_phase_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .cfg        (counts),
        .phase      (phase),
        .fin        (ack),
        .strobe_end (strobe_end)
    );

    pio_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk            (clk),
        .rst            (rst),
        .accept         (accept),
        .we             (we),
        .addr           (addr),
        .wdata          (wdata),
        .phase          (phase),
        .strobe_end     (strobe_end),
        .bus_din        (bus_din),
        .bus_addr       (bus_addr),
        .bus_addr_valid (bus_addr_valid),
        .bus_rd_n       (bus_rd_n),
        .bus_wr_n       (bus_wr_n),
        .bus_dout       (bus_dout),
        .bus_dout_en    (bus_dout_en),
        .rdata          (rdata)
    );

endmodule

// File: rtl/pio_cycle_gen_chk.sv
module pio_cycle_gen_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        active_mode,
    input logic              ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_addr_valid,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_dout_en
);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n));

    assert_read_no_drive_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !bus_dout_en);

    assert_write_drive_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> bus_dout_en);

    assert_strobe_in_window_R5: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n || !bus_wr_n) |-> bus_addr_valid);

    assert_setup_before_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(bus_addr_valid));

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_valid && $past(bus_addr_valid)) |-> $stable(bus_addr));

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    assert_ack_after_idle_bus_R6: assert property (@(posedge clk) disable iff (rst)
        ack |-> !bus_addr_valid);

    assert_mode_range_R9: assert property (@(posedge clk) disable iff (rst)
        active_mode <= 3'd4);

endmodule

bind pio_cycle_gen pio_cycle_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .active_mode    (active_mode),
    .ack            (ack),
    .bus_addr       (bus_addr),
    .bus_addr_valid (bus_addr_valid),
    .bus_rd_n       (bus_rd_n),
    .bus_wr_n       (bus_wr_n),
    .bus_dout_en    (bus_dout_en)
);

// File: tb/pio_cycle_gen_test.sv
module pio_cycle_gen_test;

    localparam int T = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_val = '0;
    logic [2:0]  active_mode;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [4:0]  bus_addr;
    logic        bus_addr_valid;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic [15:0] bus_dout;
    logic        bus_dout_en;
    logic [15:0] bus_din = 16'hDEAD;
    logic [15:0] rd_pat = 16'h0000;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pio_cycle_gen #(.CLK_NS(T), .ADDR_W(5), .DATA_W(16)) uut (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(mode_val),
        .active_mode(active_mode), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .bus_addr(bus_addr),
        .bus_addr_valid(bus_addr_valid), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din)
    );

    // Device responder: valid word only while the read strobe is low.
    always @(negedge clk) bus_din <= bus_rd_n ? 16'hDEAD : rd_pat;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cy(int ns);
        return (ns + T) / T;
    endfunction

    function automatic int e_setup(int m);
        int v[5] = '{70, 50, 30, 30, 25};
        return cy(v[m]);
    endfunction
    function automatic int e_strobe(int m);
        int v[5] = '{290, 290, 290, 80, 70};
        return cy(v[m]);
    endfunction
    function automatic int e_hold(int m);
        int d[5] = '{30, 20, 15, 10, 10};
        int a[5] = '{20, 15, 10, 10, 10};
        return (cy(d[m]) > cy(a[m])) ? cy(d[m]) : cy(a[m]);
    endfunction
    function automatic int e_total(int m);
        int c[5] = '{600, 383, 240, 180, 120};
        int busy = e_setup(m) + e_strobe(m) + e_hold(m) + 1;
        return (cy(c[m]) > busy) ? cy(c[m]) : busy;
    endfunction

    task automatic load_mode(logic [2:0] v, int exp);
        @(negedge clk);
        mode_wr  = 1'b1;
        mode_val = v;
        @(negedge clk);
        mode_wr  = 1'b0;
        chk($sformatf("R9 active mode after load %0d", v), active_mode, exp);
    endtask

    task automatic run_cycle(bit w, logic [4:0] a, logic [15:0] d, int m);
        int  s = 0, st = 0, h = 0, idx = 0;
        bit  got = 0, data_ok = 1, addr_ok = 1, saw_rd = 0, saw_wr = 0;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        if (!w) rd_pat = d;
        while (!got && idx < 400) begin
            @(negedge clk);
            idx++;
            if (ack) begin
                got = 1;
                req = 1'b0;
            end else if (!bus_rd_n || !bus_wr_n) begin
                st++;
                if (!bus_rd_n) saw_rd = 1;
                if (!bus_wr_n) saw_wr = 1;
                if (w && (!bus_dout_en || bus_dout !== d)) data_ok = 0;
            end else if (bus_addr_valid) begin
                if (st == 0) s++; else h++;
            end
            if (!w && bus_dout_en) data_ok = 0;
            if (bus_addr_valid && bus_addr !== a) addr_ok = 0;
        end
        req = 1'b0;
        chk($sformatf("R10 ack seen mode %0d", m), int'(got), 1);
        chk($sformatf("R3 setup cycles (R2) mode %0d we %0d", m, w), s, e_setup(m));
        chk($sformatf("R4 strobe cycles (R2) mode %0d we %0d", m, w), st, e_strobe(m));
        chk($sformatf("R5 hold cycles mode %0d we %0d", m, w), h, e_hold(m));
        chk($sformatf("R5 address stable mode %0d", m), int'(addr_ok), 1);
        chk($sformatf("R6 total cycles mode %0d we %0d", m, w), idx - 1, e_total(m));
        chk($sformatf("R8 strobe select/data mode %0d we %0d", m, w),
            {int'(saw_rd), int'(saw_wr), int'(data_ok)} == {int'(!w), int'(w), 1} ? 1 : 0, 1);
        if (!w) chk($sformatf("R7 read data mode %0d", m), rdata, d);
        @(negedge clk);
        chk("R10 ack one cycle", int'(ack), 0);
        chk("R10 no second cycle", int'(bus_addr_valid), 0);
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd strobe idle", int'(bus_rd_n), 1);
        chk("R1 wr strobe idle", int'(bus_wr_n), 1);
        chk("R1 address valid", int'(bus_addr_valid), 0);
        chk("R1 data enable", int'(bus_dout_en), 0);
        chk("R1 ack", int'(ack), 0);
        chk("R1 mode", active_mode, 0);

        for (int m = 0; m < 5; m++) begin
            load_mode(3'(m), m);
            run_cycle(1'b1, 5'(m + 3), 16'hA5C0 ^ 16'(m * 16'h0111), m);
            run_cycle(1'b0, 5'(m + 17), 16'h3C0F + 16'(m * 16'h1001), m);
        end

        // R7: a write between reads leaves the last read word untouched.
        run_cycle(1'b0, 5'd9, 16'hBEEF, 4);
        run_cycle(1'b1, 5'd2, 16'h1234, 4);
        chk("R7 read data held across write", rdata, 16'hBEEF);

        // R9: out-of-range loads are ignored and timing stays on mode 3.
        load_mode(3'd3, 3);
        load_mode(3'd5, 3);
        load_mode(3'd7, 3);
        run_cycle(1'b1, 5'd30, 16'h0F0F, 3);
        load_mode(3'd6, 3);
        run_cycle(1'b0, 5'd31, 16'hF00D, 3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule